// File: doc/BRIEF.md
# Prefetch Candidate Queue Manager

This block sits beside a cache and keeps a short, ordered list of cache-line prefetch candidates. When a demand miss is reported, a separate candidate generator offers block addresses, each paired with a delay. The block tags each one with a ready time. It discards candidates whose block is already pending in the miss-status holding registers (MSHRs), already queued, or (in one mode) already cached. The survivors are appended at the tail. When the memory port grants a prefetch slot, the head entry is popped and issued in that same cycle.

A new demand miss can cancel queued work. A queued entry for the missing block is deleted. In serial-squash mode, every entry at the tail whose ready time is not earlier than the miss time is dropped, one after another. Cache and MSHR lookups are combinational query ports: the block drives an aligned address and reads back a hit bit in the same cycle.

Eight event counters are provided, one per kind of event, packed into a single output vector.

Top module: `pfq_mgr`

## Requirements
- R1: The queue never holds more than DEPTH entries. Inserting while full first drops the head entry and adds one to event counter 4 (evictions).
- R2: Every address the block stores, issues or drives on a query port is block-aligned: its low log2(BLK_BYTES) bits are zero. All matching compares aligned addresses.
- R3: A miss with `miss_uncache` set is ignored. With `cfg_data_only` set, a miss with `miss_ifetch` set is also ignored. An ignored miss changes no entry, no counter and not the latched miss time.
- R4: On an accepted miss, a queued entry with the same aligned address is removed, and event counter 5 (removed by miss) adds one.
- R5: With `cfg_squash` set, an accepted miss then removes tail entries while the queue is non-empty and the tail ready time is >= `miss_time`. Event counter 7 adds one per removed entry.
- R6: A candidate's ready time is the `miss_time` latched by the most recent accepted miss plus `cand_delay`, modulo 2^TW. Entries are appended at the tail and issued strictly in arrival order.
- R7: Event counter 0 counts every accepted candidate. A candidate whose block hits the MSHR query is dropped (counter 1). Otherwise, a candidate already in the queue (excluding a head popped in the same cycle) is dropped (counter 3). Hence no two entries share an address.
- R8: With `cfg_push_check` set, a candidate that hits the cache query is dropped before the MSHR check. With it clear, a granted head that hits the cache query is discarded without issue. In both cases counter 2 adds one per such event.
- R9: `pf_req` rises in the cycle after an insertion, and `pf_req_time` then shows that entry's ready time. `pf_req` falls in the cycle after the queue becomes empty by any means.
- R10: When `pf_grant` is high, `miss_valid` is low and the queue is not empty, the head is popped in that cycle. `iss_valid` is high with `iss_addr` equal to the head unless R8 discards it. Issues add one to counter 6. While `miss_valid` is high, `cand_ready` is low and grants are ignored. Counter k occupies bits [k*CW +: CW] of `evt_counts`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch misses |
| cfg_squash | input | 1 | Enable tail squash on miss |
| cfg_push_check | input | 1 | Cache check at insertion (1) or at issue (0) |
| miss_valid | input | 1 | Demand miss event |
| miss_addr | input | AW | Miss byte address |
| miss_time | input | TW | Miss time stamp |
| miss_uncache | input | 1 | Miss is uncacheable |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | AW | Candidate byte address |
| cand_delay | input | DW | Candidate delay |
| cq_cand_addr | output | AW | Cache query address for candidate |
| cq_cand_hit | input | 1 | Cache query result for candidate |
| cq_head_addr | output | AW | Cache query address for head |
| cq_head_hit | input | 1 | Cache query result for head |
| mq_addr | output | AW | MSHR query address |
| mq_hit | input | 1 | MSHR query result |
| pf_grant | input | 1 | Port grants a prefetch slot |
| iss_valid | output | 1 | Prefetch issued this cycle |
| iss_addr | output | AW | Issued block address |
| pf_req | output | 1 | Prefetch request to the port arbiter |
| pf_req_time | output | TW | Ready time of the last inserted entry |
| evt_counts | output | 8*CW | Packed event counters |

## Verification
The bench fills the queue past DEPTH with distinct blocks. A design that evicted the tail, or forgot to shift, would issue the wrong order, and its eviction count would disagree. A grant that coincides with a candidate duplicating the head must accept the candidate; a design that matched the departing head would drop it and undercount buffer hits. Tail squash is driven with ready times equal to the miss time, so a strict comparison would leave entries behind. Uncacheable misses aimed at queued blocks, issue-time cache hits that must not raise `iss_valid`, and misses that collide with grants all appear in every combination of the three modes.

// File: rtl/pfq_pkg.sv
// Package: shared event indices for the prefetch candidate queue manager.
// Assumes: counters are packed into one vector in index order.
package pfq_pkg;
    localparam int NEV        = 8;
    localparam int EV_IDENT   = 0;
    localparam int EV_MSHR    = 1;
    localparam int EV_CACHE   = 2;
    localparam int EV_BUFHIT  = 3;
    localparam int EV_EVICT   = 4;
    localparam int EV_RMMISS  = 5;
    localparam int EV_ISSUE   = 6;
    localparam int EV_SQUASH  = 7;
endpackage

// File: rtl/pfq_match.sv
// Module: pfq_match
// Searches the valid part of the queue for an aligned address.
// Assumes: at most one entry matches, so the first match is the only one.
module pfq_match #(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0]   ent_addr [DEPTH],
    input  logic [CNTW-1:0] ent_cnt,
    input  logic [AW-1:0]   key,
    output logic            hit,
    output logic [IW-1:0]   idx
);
    // Scan entries below the count and report the first equal one.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit && (i < int'(ent_cnt)) && (ent_addr[i] == key)) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pfq_store.sv
// Module: pfq_store
// Holds the compacted entry array (index 0 is the head) and applies one
// cycle's worth of edits: on a miss, remove-at-index then tail squash;
// otherwise, head pop then tail push with eviction when full.
// Assumes: the caller never asserts pop/push in a cycle with miss_acc.
module pfq_store #(
    parameter int AW    = 32,
    parameter int TW    = 16,
    parameter int DEPTH = 8,
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            miss_acc,
    input  logic            rm_hit,
    input  logic [IW-1:0]   rm_idx,
    input  logic [TW-1:0]   miss_time,
    input  logic            squash_en,
    input  logic            pop,
    input  logic            push,
    input  logic [AW-1:0]   push_addr,
    input  logic [TW-1:0]   push_rdy,
    output logic [AW-1:0]   q_addr [DEPTH],
    output logic [TW-1:0]   q_rdy  [DEPTH],
    output logic [CNTW-1:0] q_cnt,
    output logic [CNTW-1:0] n_squashed,
    output logic            evicted,
    output logic            empty_next
);
    logic [AW-1:0]   w_addr [DEPTH];
    logic [TW-1:0]   w_rdy  [DEPTH];
    logic [CNTW-1:0] cnt_next;

    // Compute the next entry array and count from this cycle's edits.
    always_comb begin
        int n;
        int sq;
        w_addr  = q_addr;
        w_rdy   = q_rdy;
        n       = int'(q_cnt);
        sq      = 0;
        evicted = 1'b0;
        if (miss_acc) begin
            if (rm_hit) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    if (i >= int'(rm_idx)) begin
                        w_addr[i] = w_addr[i+1];
                        w_rdy[i]  = w_rdy[i+1];
                    end
                end
                n = n - 1;
            end
            if (squash_en) begin
                for (int i = DEPTH - 1; i >= 0; i--) begin
                    if ((n > 0) && (i == n - 1) && (w_rdy[i] >= miss_time)) begin
                        n  = n - 1;
                        sq = sq + 1;
                    end
                end
            end
        end else begin
            if (pop) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    w_addr[i] = w_addr[i+1];
                    w_rdy[i]  = w_rdy[i+1];
                end
                n = n - 1;
            end
            if (push) begin
                if (n == DEPTH) begin
                    for (int i = 0; i < DEPTH - 1; i++) begin
                        w_addr[i] = w_addr[i+1];
                        w_rdy[i]  = w_rdy[i+1];
                    end
                    n       = n - 1;
                    evicted = 1'b1;
                end
                for (int i = 0; i < DEPTH; i++) begin
                    if (i == n) begin
                        w_addr[i] = push_addr;
                        w_rdy[i]  = push_rdy;
                    end
                end
                n = n + 1;
            end
        end
        cnt_next   = CNTW'(n);
        n_squashed = CNTW'(sq);
        empty_next = (n == 0);
    end

    // Register the entry array and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                q_addr[i] <= '0;
                q_rdy[i]  <= '0;
            end
            q_cnt <= '0;
        end else begin
            q_addr <= w_addr;
            q_rdy  <= w_rdy;
            q_cnt  <= cnt_next;
        end
    end

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CNTW'(DEPTH));
endmodule

// File: rtl/pfq_events.sv
// Module: pfq_events
// A bank of wrapping event counters, each advanced by a small amount.
// Assumes: amounts are already zero when the event did not occur.
module pfq_events #(
    parameter int NEV = 8,
    parameter int CW  = 16,
    parameter int AMW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEV*AMW-1:0] amt_flat,
    output logic [NEV*CW-1:0]  cnt_flat
);
    for (genvar g = 0; g < NEV; g++) begin : g_ctr
        logic [CW-1:0] val;
        // Accumulate this event's amount.
        always_ff @(posedge clk) begin
            if (!rst_n) val <= '0;
            else        val <= val + CW'(amt_flat[g*AMW +: AMW]);
        end
        assign cnt_flat[g*CW +: CW] = val;
    end
endmodule

// File: rtl/pfq_mgr.sv
// Module: pfq_mgr (top)
// Prefetch candidate queue manager: filters candidates against cache, MSHR
// and queue contents, keeps them in arrival order, issues the head on grant,
// and cancels queued work on demand misses.
// Assumes: cache/MSHR query ports answer combinationally in the same cycle;
// a miss event has priority over candidate intake and issue.
module pfq_mgr
    import pfq_pkg::*;
#(
    parameter int AW        = 32,
    parameter int TW        = 16,
    parameter int DW        = 8,
    parameter int BLK_BYTES = 64,
    parameter int DEPTH     = 8,
    parameter int CW        = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_data_only,
    input  logic                cfg_squash,
    input  logic                cfg_push_check,
    input  logic                miss_valid,
    input  logic [AW-1:0]       miss_addr,
    input  logic [TW-1:0]       miss_time,
    input  logic                miss_uncache,
    input  logic                miss_ifetch,
    input  logic                cand_valid,
    output logic                cand_ready,
    input  logic [AW-1:0]       cand_addr,
    input  logic [DW-1:0]       cand_delay,
    output logic [AW-1:0]       cq_cand_addr,
    input  logic                cq_cand_hit,
    output logic [AW-1:0]       cq_head_addr,
    input  logic                cq_head_hit,
    output logic [AW-1:0]       mq_addr,
    input  logic                mq_hit,
    input  logic                pf_grant,
    output logic                iss_valid,
    output logic [AW-1:0]       iss_addr,
    output logic                pf_req,
    output logic [TW-1:0]       pf_req_time,
    output logic [NEV*CW-1:0]   evt_counts
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int AMW  = CNTW;
    localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(BLK_BYTES) - AW'(1));

    logic [AW-1:0]   q_addr [DEPTH];
    logic [TW-1:0]   q_rdy  [DEPTH];
    logic [CNTW-1:0] q_cnt;
    logic [CNTW-1:0] n_squashed;
    logic            evicted, empty_next;
    logic [TW-1:0]   base_time;

    logic [AW-1:0]   miss_key, cand_key;
    logic            miss_acc, cand_acc;
    logic            m_hit, c_hit;
    logic [IW-1:0]   m_idx, c_idx;
    logic            grant_eff, head_drop;
    logic            drop_cache, drop_mshr, drop_dup, do_push;
    logic [TW-1:0]   push_rdy;
    logic [NEV*AMW-1:0] amt_flat;

    // Decode miss acceptance, alignment and intake/issue gating.
    always_comb begin
        miss_key   = miss_addr & ALIGN_MASK;
        cand_key   = cand_addr & ALIGN_MASK;
        miss_acc   = miss_valid && !miss_uncache && !(cfg_data_only && miss_ifetch);
        cand_ready = !miss_valid;
        cand_acc   = cand_valid && !miss_valid;
        grant_eff  = pf_grant && !miss_valid && (q_cnt != '0);
        head_drop  = !cfg_push_check && cq_head_hit;
        iss_valid  = grant_eff && !head_drop;
        iss_addr   = q_addr[0];
        cq_head_addr = q_addr[0];
        cq_cand_addr = cand_key;
        mq_addr      = cand_key;
        push_rdy     = base_time + TW'(cand_delay);
    end

    pfq_match #(.AW(AW), .DEPTH(DEPTH)) u_miss_match (
        .ent_addr(q_addr), .ent_cnt(q_cnt), .key(miss_key),
        .hit(m_hit), .idx(m_idx));

    pfq_match #(.AW(AW), .DEPTH(DEPTH)) u_cand_match (
        .ent_addr(q_addr), .ent_cnt(q_cnt), .key(cand_key),
        .hit(c_hit), .idx(c_idx));

    // Candidate filter chain: cache (push mode), MSHR, then queue duplicate.
    always_comb begin
        drop_cache = cfg_push_check && cq_cand_hit;
        drop_mshr  = !drop_cache && mq_hit;
        drop_dup   = !drop_cache && !mq_hit && c_hit && !(grant_eff && (c_idx == '0));
        do_push    = cand_acc && !drop_cache && !drop_mshr && !drop_dup;
    end

    pfq_store #(.AW(AW), .TW(TW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .miss_acc(miss_acc), .rm_hit(miss_acc && m_hit), .rm_idx(m_idx),
        .miss_time(miss_time), .squash_en(cfg_squash),
        .pop(grant_eff), .push(do_push),
        .push_addr(cand_key), .push_rdy(push_rdy),
        .q_addr(q_addr), .q_rdy(q_rdy), .q_cnt(q_cnt),
        .n_squashed(n_squashed), .evicted(evicted), .empty_next(empty_next));

    // Latch the time stamp of each accepted miss as the candidate base.
    always_ff @(posedge clk) begin
        if (!rst_n)        base_time <= '0;
        else if (miss_acc) base_time <= miss_time;
    end

    // Raise the arbiter request on insertion, drop it when the queue empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_req      <= 1'b0;
            pf_req_time <= '0;
        end else if (do_push) begin
            pf_req      <= 1'b1;
            pf_req_time <= push_rdy;
        end else if (empty_next) begin
            pf_req      <= 1'b0;
        end
    end

    // Gather per-event increments for the counter bank.
    always_comb begin
        amt_flat = '0;
        amt_flat[EV_IDENT*AMW  +: AMW] = AMW'(cand_acc);
        amt_flat[EV_MSHR*AMW   +: AMW] = AMW'(cand_acc && drop_mshr);
        amt_flat[EV_CACHE*AMW  +: AMW] = AMW'(cand_acc && drop_cache)
                                       + AMW'(grant_eff && head_drop);
        amt_flat[EV_BUFHIT*AMW +: AMW] = AMW'(cand_acc && drop_dup);
        amt_flat[EV_EVICT*AMW  +: AMW] = AMW'(evicted);
        amt_flat[EV_RMMISS*AMW +: AMW] = AMW'(miss_acc && m_hit);
        amt_flat[EV_ISSUE*AMW  +: AMW] = AMW'(iss_valid);
        amt_flat[EV_SQUASH*AMW +: AMW] = n_squashed;
    end

    pfq_events #(.NEV(NEV), .CW(CW), .AMW(AMW)) u_events (
        .clk(clk), .rst_n(rst_n), .amt_flat(amt_flat), .cnt_flat(evt_counts));

    // Tail ready time, used only by the squash check below.
    logic [TW-1:0] tail_rdy;
    always_comb begin
        tail_rdy = '0;
        for (int i = 0; i < DEPTH; i++)
            if (i + 1 == int'(q_cnt)) tail_rdy = q_rdy[i];
    end

    a_r9_req_low_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt == '0) |-> !pf_req);

    a_r10_miss_blocks_intake: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (!cand_ready && !iss_valid));

    a_r5_squash_leaves_early_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_acc && cfg_squash) |=> ((q_cnt == '0) || (tail_rdy < $past(miss_time))));

    a_r2_issue_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((iss_addr & ~ALIGN_MASK) == '0));

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_uq_i
        for (genvar gj = gi + 1; gj < DEPTH; gj++) begin : g_uq_j
            a_r7_unique_entries: assert property (@(posedge clk) disable iff (!rst_n)
                (CNTW'(gj) < q_cnt) |-> (q_addr[gi] != q_addr[gj]));
        end
    end
endmodule

// File: tb/pfq_mgr_bench.sv
// Bench for pfq_mgr: random traffic across all mode combinations plus
// directed corner cases, compared each cycle against a queue model.
module pfq_mgr_bench;
    localparam int AW = 32, TW = 16, DW = 8, BLK = 64, DEPTH = 8, CW = 16, NEV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_data_only = 0, cfg_squash = 0, cfg_push_check = 0;
    logic miss_valid = 0, miss_uncache = 0, miss_ifetch = 0;
    logic [AW-1:0] miss_addr = '0;
    logic [TW-1:0] miss_time = '0;
    logic cand_valid = 0;
    logic [AW-1:0] cand_addr = '0;
    logic [DW-1:0] cand_delay = '0;
    logic pf_grant = 0;
    logic cand_ready, iss_valid, pf_req;
    logic [AW-1:0] cq_cand_addr, cq_head_addr, mq_addr, iss_addr;
    logic cq_cand_hit, cq_head_hit, mq_hit;
    logic [TW-1:0] pf_req_time;
    logic [NEV*CW-1:0] evt_counts;

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] algn(input logic [AW-1:0] a);
        return a & ~AW'(BLK - 1);
    endfunction
    function automatic logic env_cache(input logic [AW-1:0] a);
        return ((a / BLK) % 5) == 0;
    endfunction
    function automatic logic env_mshr(input logic [AW-1:0] a);
        return ((a / BLK) % 7) == 3;
    endfunction

    always_comb begin
        cq_cand_hit = env_cache(cq_cand_addr);
        cq_head_hit = env_cache(cq_head_addr);
        mq_hit      = env_mshr(mq_addr);
    end

    pfq_mgr #(.AW(AW), .TW(TW), .DW(DW), .BLK_BYTES(BLK), .DEPTH(DEPTH), .CW(CW)) u_pfq_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_data_only(cfg_data_only), .cfg_squash(cfg_squash),
        .cfg_push_check(cfg_push_check), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_time(miss_time), .miss_uncache(miss_uncache), .miss_ifetch(miss_ifetch),
        .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
        .cand_delay(cand_delay), .cq_cand_addr(cq_cand_addr), .cq_cand_hit(cq_cand_hit),
        .cq_head_addr(cq_head_addr), .cq_head_hit(cq_head_hit), .mq_addr(mq_addr),
        .mq_hit(mq_hit), .pf_grant(pf_grant), .iss_valid(iss_valid), .iss_addr(iss_addr),
        .pf_req(pf_req), .pf_req_time(pf_req_time), .evt_counts(evt_counts));

    int total = 0, bad = 0;
    bit finished = 0;

    // model state
    logic [AW-1:0] m_addr [DEPTH];
    logic [TW-1:0] m_rdy  [DEPTH];
    int m_n;
    logic [TW-1:0] m_base, m_req_time;
    logic m_req;
    int m_cnt [NEV];
    logic e_iss, e_ready;
    logic [AW-1:0] e_iss_addr;
    string ev_tag [NEV] = '{"R7", "R7", "R8", "R7", "R1", "R4", "R10", "R5"};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_n = 0; m_base = '0; m_req = 0; m_req_time = '0;
        for (int k = 0; k < NEV; k++) m_cnt[k] = 0;
        for (int k = 0; k < DEPTH; k++) begin m_addr[k] = '0; m_rdy[k] = '0; end
    endtask

    task automatic m_del(input int k);
        for (int j = k; j < DEPTH - 1; j++) begin m_addr[j] = m_addr[j+1]; m_rdy[j] = m_rdy[j+1]; end
        m_n--;
    endtask

    // advance the model by one cycle of the current inputs
    task automatic model_step();
        bit ins = 0;
        e_ready = !miss_valid; e_iss = 0; e_iss_addr = '0;
        if (miss_valid) begin
            if (!miss_uncache && !(cfg_data_only && miss_ifetch)) begin
                m_base = miss_time;
                for (int k = 0; k < m_n; k++)
                    if (m_addr[k] == algn(miss_addr)) begin m_del(k); m_cnt[5]++; break; end
                if (cfg_squash)
                    while (m_n > 0 && m_rdy[m_n-1] >= miss_time) begin m_n--; m_cnt[7]++; end
            end
        end else begin
            if (pf_grant && m_n > 0) begin
                logic [AW-1:0] h = m_addr[0];
                m_del(0);
                if (!cfg_push_check && env_cache(h)) m_cnt[2]++;
                else begin e_iss = 1; e_iss_addr = h; m_cnt[6]++; end
            end
            if (cand_valid) begin
                logic [AW-1:0] a = algn(cand_addr);
                bit dup = 0;
                m_cnt[0]++;
                for (int k = 0; k < m_n; k++) if (m_addr[k] == a) dup = 1;
                if (cfg_push_check && env_cache(a)) m_cnt[2]++;
                else if (env_mshr(a)) m_cnt[1]++;
                else if (dup) m_cnt[3]++;
                else begin
                    if (m_n == DEPTH) begin m_del(0); m_cnt[4]++; end
                    m_addr[m_n] = a; m_rdy[m_n] = m_base + TW'(cand_delay); m_n++;
                    ins = 1; m_req_time = m_base + TW'(cand_delay);
                end
            end
        end
        if (ins) m_req = 1; else if (m_n == 0) m_req = 0;
    endtask

    // one clock: inputs already set after a negedge
    task automatic cyc();
        #1;
        model_step();
        chk("R10 cand_ready", 64'(cand_ready), 64'(e_ready));
        chk("R10 iss_valid", 64'(iss_valid), 64'(e_iss));
        if (e_iss) begin
            chk("R6 iss_addr order", 64'(iss_addr), 64'(e_iss_addr));
            chk("R2 iss_addr aligned", 64'(iss_addr % BLK), 64'd0);
        end
        @(posedge clk); #1;
        chk("R9 pf_req", 64'(pf_req), 64'(m_req));
        if (m_req) chk("R6 pf_req_time", 64'(pf_req_time), 64'(m_req_time));
        @(negedge clk);
        miss_valid = 0; cand_valid = 0; pf_grant = 0; miss_uncache = 0; miss_ifetch = 0;
    endtask

    task automatic chk_counts(input string where);
        for (int k = 0; k < NEV; k++)
            chk($sformatf("%s %s counter%0d", ev_tag[k], where, k),
                64'(evt_counts[k*CW +: CW]), 64'(m_cnt[k] % (1 << CW)));
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic put_cand(input int blk, input int dly);
        cand_valid = 1; cand_addr = AW'(blk * BLK + 17); cand_delay = DW'(dly);
    endtask
    task automatic put_miss(input int blk, input int t, input bit unc, input bit ifet);
        miss_valid = 1; miss_addr = AW'(blk * BLK + 5); miss_time = TW'(t);
        miss_uncache = unc; miss_ifetch = ifet;
    endtask

    // blocks that hit neither cache nor MSHR in the environment
    function automatic int clean_blk(input int i);
        int b = 100, c = 0;
        while (1) begin
            if ((b % 5) != 0 && (b % 7) != 3) begin
                if (c == i) return b;
                c++;
            end
            b++;
        end
    endfunction

    initial begin
        int tnow;
        void'($urandom(32'd1357));
        do_reset();
        // reset state
        chk("R9 reset pf_req", 64'(pf_req), 64'd0);
        chk("R10 reset iss_valid", 64'(iss_valid), 64'd0);
        chk_counts("reset");

        // R1: fill past depth with distinct clean blocks, then drain in order
        put_miss(clean_blk(40), 10, 0, 0); cyc();
        for (int i = 0; i < DEPTH + 2; i++) begin put_cand(clean_blk(i), i); cyc(); end
        chk("R1 evictions after overfill", 64'(evt_counts[4*CW +: CW]), 64'd2);
        // R3: uncacheable miss to a queued block is ignored
        put_miss(clean_blk(5), 3, 1, 0); cyc();
        chk("R3 uncacheable ignored", 64'(evt_counts[5*CW +: CW]), 64'd0);
        // R4: accepted miss removes the queued block
        put_miss(clean_blk(5), 3, 0, 0); cyc();
        chk("R4 removed by miss", 64'(evt_counts[5*CW +: CW]), 64'd1);
        // R7: grant plus candidate equal to departing head is accepted
        pf_grant = 1; put_cand(clean_blk(2), 1); cyc();
        chk("R7 head duplicate accepted", 64'(evt_counts[3*CW +: CW]), 64'd0);
        // R5: squash with ready times equal to miss time
        cfg_squash = 1;
        put_miss(clean_blk(41), 20, 0, 0); cyc();
        put_cand(clean_blk(30), 0); cyc();
        put_cand(clean_blk(31), 0); cyc();
        put_miss(clean_blk(42), 20, 0, 0); cyc();
        chk("R5 equal time squashed", 64'(evt_counts[7*CW +: CW] >= 2), 64'd1);
        while (m_n > 0) begin pf_grant = 1; cyc(); end
        chk("R9 pf_req drops when empty", 64'(pf_req), 64'd0);
        chk_counts("directed");

        // random traffic over all mode combinations
        for (int m = 0; m < 8; m++) begin
            do_reset();
            cfg_data_only = m[0]; cfg_squash = m[1]; cfg_push_check = m[2];
            tnow = 0;
            for (int c = 0; c < 500; c++) begin
                if ($urandom % 6 == 0) begin
                    tnow += $urandom % 4;
                    put_miss(64 + $urandom % 24, tnow, ($urandom % 5) == 0, ($urandom % 3) == 0);
                end
                if ($urandom % 3 != 0) put_cand(64 + $urandom % 24, $urandom % 6);
                pf_grant = ($urandom % 3) == 0;
                cyc();
            end
            chk_counts($sformatf("mode%0d", m));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule